// File: doc/BRIEF.md
# Single-Wire Bus Slave Bit Timing Front End

This block is the bit-level edge of a slave on a single-wire open-drain bus. It watches the line level and drives one output, an active-high pull-down enable. It never drives the line high. A long low period from the master counts as a bus reset. After the master lets the line go, the block waits a fixed delay and then pulls the line low for a while, so the master can see that a device is present.

Every other exchange is a one-bit time slot, and the master always opens it with a falling edge. That edge starts a timer inside the block. Before the slot, the device logic states the slot's direction on `tx_mode_i` and the bit to send on `tx_bit_i`. In a write slot the block samples the line at a fixed point. In a read slot it either holds the line low for a fixed time or leaves it alone. After the line comes back high, the block waits out a recovery interval before it accepts another slot.

Time is counted in clock cycles, called ticks. `line_i` must already be synchronized to `clk`.

Top module: `swb_front`

## Requirements
- R1: While `rst_n` is low, and after it rises with the line idle high, `pull_o`, `rx_stb_o` and `rst_stb_o` are all 0.
- R2: With `tx_mode_i`=0 (write) captured at the falling edge, the line is sampled SAMPLE_TICKS (30) cycles after the first clock edge that sees it low. A high sample gives bit 1 and a low sample gives bit 0. The result appears on `rx_bit_o` with a one-cycle `rx_stb_o` pulse. A master low of 30 cycles reads as 1 and a low of 31 cycles reads as 0.
- R3: With `tx_mode_i`=1 (read) and `tx_bit_i`=0 captured at the falling edge, `pull_o` is high for exactly READ_HOLD_TICKS (30) cycles, starting right after the edge that sees the fall. No `rx_stb_o` is produced.
- R4: With `tx_mode_i`=1 and `tx_bit_i`=1, `pull_o` stays 0 for the whole slot, and no `rx_stb_o` is produced.
- R5: A master low lasting RESET_TICKS (400) cycles gives exactly one `rst_stb_o` pulse for that low period. This holds even when the low period began as a slot.
- R6: After the rise that ends a reset, `pull_o` stays 0 for PRES_WAIT_TICKS (30) cycles and is then high for PRES_LOW_TICKS (120) cycles.
- R7: A falling edge that comes within RECOVERY_TICKS (10) cycles after the line returns high at the end of a slot starts no slot and produces no `rx_stb_o`.
- R8: `pull_o` is never asserted during a write slot or during the master's reset low.
- R9: A falling edge after recovery has ended is accepted as a new slot.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock; one cycle is one tick |
| rst_n | input | 1 | Synchronous active-low reset |
| line_i | input | 1 | Synchronized bus level (1 = released/high) |
| tx_mode_i | input | 1 | Direction of the next slot: 1 = read (slave sends), 0 = write |
| tx_bit_i | input | 1 | Bit to send in the next read slot |
| pull_o | output | 1 | Pull-down enable for the open-drain bus |
| rx_stb_o | output | 1 | One-cycle strobe when a write bit has been sampled |
| rx_bit_o | output | 1 | Value of the last sampled write bit |
| rst_stb_o | output | 1 | One-cycle strobe when a bus reset is recognised |

## Verification
Write slots are run with master low times of 5, 30, 31 and 60 ticks. The 30- and 31-tick lows sit on either side of the sample point, so they show whether it falls one tick too early or too late. Read slots are run with each bit value. The number of cycles `pull_o` is high tells a correct hold time from an off-by-one or a missing drive. A long low that starts as a write slot checks that the reset is still recognised once, and that the presence delay and width are exact to the cycle. A second low placed inside the recovery window, followed by a clean slot, tells apart a recovery guard that ignores the edge, one that accepts it, and one that never lets the bus go back to idle.

// File: rtl/swb_pkg.sv
// Package: shared types for the single-wire slave front end.
// Assumes: nothing beyond IEEE 1800-2017 enums.
package swb_pkg;

    // Bus-level states of the slave timing engine
    typedef enum logic [2:0] {
        ST_IDLE      = 3'd0,
        ST_SLOT      = 3'd1,
        ST_WAIT_HI   = 3'd2,
        ST_RECOV     = 3'd3,
        ST_RST_LOW   = 3'd4,
        ST_PRES_WAIT = 3'd5,
        ST_PRES_LOW  = 3'd6
    } swb_state_e;

endpackage

// File: rtl/swb_interval_timer.sv
// Module: tick counter shared by all timed phases.
// Counts up from zero after a clear and saturates at its maximum.
// Assumes: the caller clears it on every phase entry.
module swb_interval_timer #(
    parameter int W = 9
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         clr_i,
    output logic [W-1:0] cnt_o
);
    localparam logic [W-1:0] CNT_MAX = {W{1'b1}};

    // Clear, count, or hold at saturation
    always_ff @(posedge clk) begin
        if (!rst_n)
            cnt_o <= '0;
        else if (clr_i)
            cnt_o <= '0;
        else if (cnt_o != CNT_MAX)
            cnt_o <= cnt_o + 1'b1;
    end
endmodule

// File: rtl/swb_reset_watch.sv
// Module: bus reset recogniser.
// Measures how long the master keeps the line low. The device's own
// pull-down is excluded. Pulses hit_o once when the low reaches RESET_TICKS.
// Assumes: line_i is synchronized.
module swb_reset_watch #(
    parameter int RESET_TICKS = 400,
    parameter int W           = 10
) (
    input  logic clk,
    input  logic rst_n,
    input  logic line_i,
    input  logic own_pull_i,
    output logic hit_o
);
    logic [W-1:0] low_cnt;

    // Track the master's low length and flag the threshold crossing once
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            low_cnt <= '0;
            hit_o   <= 1'b0;
        end else begin
            hit_o <= !line_i && !own_pull_i && (low_cnt == W'(RESET_TICKS - 1));
            if (line_i || own_pull_i)
                low_cnt <= '0;
            else if (low_cnt != W'(RESET_TICKS))
                low_cnt <= low_cnt + 1'b1;
        end
    end

    // R5
    rst_low_chk: assert property (@(posedge clk) disable iff (!rst_n)
        hit_o |-> $past(!line_i));

    // R5
    rst_once_chk: assert property (@(posedge clk) disable iff (!rst_n)
        hit_o |=> !hit_o);
endmodule

// File: rtl/swb_slot_fsm.sv
// Module: slot and presence sequencer.
// Starts a slot on a falling edge seen while idle, samples write bits,
// drives read zeros and the presence pulse, and applies the recovery guard.
// Assumes: t_i is a timer that reads 0 in the cycle after tmr_clr_o.
module swb_slot_fsm
    import swb_pkg::*;
#(
    parameter int SAMPLE_TICKS    = 30,
    parameter int READ_HOLD_TICKS = 30,
    parameter int PRES_WAIT_TICKS = 30,
    parameter int PRES_LOW_TICKS  = 120,
    parameter int RECOVERY_TICKS  = 10,
    parameter int W               = 10
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         line_i,
    input  logic         tx_mode_i,
    input  logic         tx_bit_i,
    input  logic         rst_hit_i,
    input  logic [W-1:0] t_i,
    output logic         tmr_clr_o,
    output logic         pull_o,
    output logic         rx_stb_o,
    output logic         rx_bit_o
);
    swb_state_e state, nxt;
    logic       rd_q, bit_q;
    logic       slot_end, sample_now;

    // Slot length depends on the direction captured at the falling edge
    always_comb begin
        slot_end   = rd_q ? (t_i == W'(READ_HOLD_TICKS - 1)) : (t_i == W'(SAMPLE_TICKS - 1));
        sample_now = (state == ST_SLOT) && !rd_q && (t_i == W'(SAMPLE_TICKS - 1));
    end

    // Next-state and timer-clear decision
    always_comb begin
        nxt       = state;
        tmr_clr_o = 1'b0;
        case (state)
            ST_IDLE:      if (!line_i) begin nxt = ST_SLOT; tmr_clr_o = 1'b1; end
            ST_SLOT:      if (slot_end) nxt = ST_WAIT_HI;
            ST_WAIT_HI:   if (line_i) begin nxt = ST_RECOV; tmr_clr_o = 1'b1; end
            ST_RECOV:     if (!line_i) nxt = ST_WAIT_HI;
                          else if (t_i == W'(RECOVERY_TICKS - 1)) nxt = ST_IDLE;
            ST_RST_LOW:   if (line_i) begin nxt = ST_PRES_WAIT; tmr_clr_o = 1'b1; end
            ST_PRES_WAIT: if (t_i == W'(PRES_WAIT_TICKS - 1)) begin
                              nxt = ST_PRES_LOW; tmr_clr_o = 1'b1;
                          end
            ST_PRES_LOW:  if (t_i == W'(PRES_LOW_TICKS - 1)) nxt = ST_WAIT_HI;
            default:      nxt = ST_IDLE;
        endcase
        if (rst_hit_i) begin
            nxt       = ST_RST_LOW;
            tmr_clr_o = 1'b1;
        end
    end

    // State register and capture of the slot's direction and bit
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state <= ST_IDLE;
            rd_q  <= 1'b0;
            bit_q <= 1'b1;
        end else begin
            state <= nxt;
            if (state == ST_IDLE && !line_i) begin
                rd_q  <= tx_mode_i;
                bit_q <= tx_bit_i;
            end
        end
    end

    // Registered write-bit result
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            rx_stb_o <= 1'b0;
            rx_bit_o <= 1'b0;
        end else begin
            rx_stb_o <= sample_now && !rst_hit_i;
            if (sample_now)
                rx_bit_o <= line_i;
        end
    end

    // Pull-down only for a read zero or the presence reply
    assign pull_o = ((state == ST_SLOT) && rd_q && !bit_q) || (state == ST_PRES_LOW);

    // R4
    rd_one_silent_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ST_SLOT && rd_q && bit_q) |-> !pull_o);

    // R2
    rx_single_chk: assert property (@(posedge clk) disable iff (!rst_n)
        rx_stb_o |=> !rx_stb_o);

    // R6
    pres_order_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ST_PRES_LOW && $past(state) != ST_PRES_LOW) |-> $past(state == ST_PRES_WAIT));

    // R7
    recov_noslot_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ST_RECOV && !line_i && !rst_hit_i) |=> (state == ST_WAIT_HI));
endmodule

// File: rtl/swb_front.sv
// Module: top of the single-wire slave bit timing front end.
// Wires the shared tick timer, the reset recogniser and the slot sequencer.
// Assumes: one clock cycle per tick; line_i already synchronized.
module swb_front #(
    parameter int SAMPLE_TICKS    = 30,
    parameter int READ_HOLD_TICKS = 30,
    parameter int PRES_WAIT_TICKS = 30,
    parameter int PRES_LOW_TICKS  = 120,
    parameter int RECOVERY_TICKS  = 10,
    parameter int RESET_TICKS     = 400
) (
    input  logic clk,
    input  logic rst_n,
    input  logic line_i,
    input  logic tx_mode_i,
    input  logic tx_bit_i,
    output logic pull_o,
    output logic rx_stb_o,
    output logic rx_bit_o,
    output logic rst_stb_o
);
    localparam int M1   = (SAMPLE_TICKS > READ_HOLD_TICKS) ? SAMPLE_TICKS : READ_HOLD_TICKS;
    localparam int M2   = (PRES_WAIT_TICKS > PRES_LOW_TICKS) ? PRES_WAIT_TICKS : PRES_LOW_TICKS;
    localparam int M3   = (M1 > M2) ? M1 : M2;
    localparam int TMAX = (M3 > RECOVERY_TICKS) ? M3 : RECOVERY_TICKS;
    localparam int TW   = $clog2(TMAX + 1) + 1;
    localparam int RW   = $clog2(RESET_TICKS + 1) + 1;

    logic          tmr_clr;
    logic [TW-1:0] t_cnt;
    logic          rst_hit;

    swb_interval_timer #(.W(TW)) u_timer (
        .clk   (clk),
        .rst_n (rst_n),
        .clr_i (tmr_clr),
        .cnt_o (t_cnt)
    );

    swb_reset_watch #(.RESET_TICKS(RESET_TICKS), .W(RW)) u_rwatch (
        .clk        (clk),
        .rst_n      (rst_n),
        .line_i     (line_i),
        .own_pull_i (pull_o),
        .hit_o      (rst_hit)
    );

    swb_slot_fsm #(
        .SAMPLE_TICKS    (SAMPLE_TICKS),
        .READ_HOLD_TICKS (READ_HOLD_TICKS),
        .PRES_WAIT_TICKS (PRES_WAIT_TICKS),
        .PRES_LOW_TICKS  (PRES_LOW_TICKS),
        .RECOVERY_TICKS  (RECOVERY_TICKS),
        .W               (TW)
    ) u_fsm (
        .clk       (clk),
        .rst_n     (rst_n),
        .line_i    (line_i),
        .tx_mode_i (tx_mode_i),
        .tx_bit_i  (tx_bit_i),
        .rst_hit_i (rst_hit),
        .t_i       (t_cnt),
        .tmr_clr_o (tmr_clr),
        .pull_o    (pull_o),
        .rx_stb_o  (rx_stb_o),
        .rx_bit_o  (rx_bit_o)
    );

    assign rst_stb_o = rst_hit;
endmodule

// File: tb/sim_swb_front.sv
// Directed bench for swb_front: one task per scenario, open-drain line model.
module sim_swb_front;
    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic master_low = 1'b0;
    logic tx_mode = 1'b0;
    logic tx_bit = 1'b1;
    logic line_w;
    logic pull_o, rx_stb_o, rx_bit_o, rst_stb_o;

    int checks = 0;
    int failures = 0;
    int rx_n = 0, rst_n_cnt = 0, pull_n = 0;
    logic rx_last = 1'b0;

    always #10 clk = ~clk;

    assign line_w = !(master_low || pull_o);

    swb_front u0 (
        .clk       (clk),
        .rst_n     (rst_n),
        .line_i    (line_w),
        .tx_mode_i (tx_mode),
        .tx_bit_i  (tx_bit),
        .pull_o    (pull_o),
        .rx_stb_o  (rx_stb_o),
        .rx_bit_o  (rx_bit_o),
        .rst_stb_o (rst_stb_o)
    );

    // Event counters sampled away from the active edge
    always @(negedge clk) begin
        if (rst_n) begin
            if (rx_stb_o) begin rx_n++; rx_last = rx_bit_o; end
            if (rst_stb_o) rst_n_cnt++;
            if (pull_o) pull_n++;
        end
    end

    task automatic check(input bit ok, input string tag, input int act, input int exp);
        checks++;
        if (!ok) begin
            failures++;
            $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
        end
    endtask

    // Master holds the line low for low_len cycles, then idles for gap cycles
    task automatic do_slot(input int low_len, input int gap);
        @(negedge clk);
        master_low = 1'b1;
        repeat (low_len) @(negedge clk);
        master_low = 1'b0;
        repeat (gap) @(negedge clk);
    endtask

    task automatic t_reset_state();
        repeat (3) @(negedge clk);
        check(!pull_o && !rx_stb_o && !rst_stb_o, "R1 in reset", {pull_o, rx_stb_o, rst_stb_o}, 0);
        rst_n = 1'b1;
        repeat (20) @(negedge clk);
        check(!pull_o && !rx_stb_o && !rst_stb_o, "R1 after reset", {pull_o, rx_stb_o, rst_stb_o}, 0);
        check(rx_n == 0 && rst_n_cnt == 0, "R1 no strobes", rx_n + rst_n_cnt, 0);
    endtask

    task automatic t_write(input int low_len, input bit exp_bit, input string tag);
        int rx0 = rx_n, p0 = pull_n;
        tx_mode = 1'b0;
        do_slot(low_len, 70);
        check(rx_n - rx0 == 1, {tag, " strobe count"}, rx_n - rx0, 1);
        check(rx_last == exp_bit, {tag, " bit"}, int'(rx_last), int'(exp_bit));
        check(pull_n == p0, {"R8 no pull in ", tag}, pull_n - p0, 0);
    endtask

    task automatic t_read(input bit b, input int exp_pull, input string tag);
        int rx0 = rx_n, p0 = pull_n;
        tx_mode = 1'b1;
        tx_bit = b;
        do_slot(2, 70);
        check(pull_n - p0 == exp_pull, {tag, " pull cycles"}, pull_n - p0, exp_pull);
        check(rx_n == rx0, {tag, " no rx strobe"}, rx_n - rx0, 0);
        tx_mode = 1'b0;
        tx_bit = 1'b1;
    endtask

    task automatic t_reset_presence();
        int r0 = rst_n_cnt, p0 = pull_n, rx0 = rx_n;
        int d = 0, len = 0;
        tx_mode = 1'b0;
        @(negedge clk);
        master_low = 1'b1;
        repeat (450) @(negedge clk);
        check(rst_n_cnt - r0 == 1, "R5 one reset strobe", rst_n_cnt - r0, 1);
        check(pull_n == p0, "R8 no pull during reset low", pull_n - p0, 0);
        check(rx_n - rx0 == 1 && rx_last == 1'b0, "R5 slot sampled before abort", rx_n - rx0, 1);
        master_low = 1'b0;
        for (int i = 0; i < 1000; i++) begin
            @(negedge clk);
            if (pull_o) break;
            d++;
        end
        check(d == 30, "R6 presence wait", d, 30);
        len = 1;
        for (int i = 0; i < 1000; i++) begin
            @(negedge clk);
            if (!pull_o) break;
            len++;
        end
        check(len == 120, "R6 presence width", len, 120);
        repeat (40) @(negedge clk);
        check(rst_n_cnt - r0 == 1, "R5 still one reset strobe", rst_n_cnt - r0, 1);
    endtask

    task automatic t_recovery();
        int rx0 = rx_n;
        tx_mode = 1'b0;
        do_slot(5, 28);
        do_slot(5, 70);
        check(rx_n - rx0 == 1, "R7 edge in recovery ignored", rx_n - rx0, 1);
        check(rx_last == 1'b1, "R7 first slot bit", int'(rx_last), 1);
        rx0 = rx_n;
        do_slot(60, 70);
        check(rx_n - rx0 == 1 && rx_last == 1'b0, "R9 slot after recovery", rx_n - rx0, 1);
    endtask

    // Watchdog: a hung run counts as a failure and still reports
    initial begin
        repeat (200000) @(posedge clk);
        failures++;
        $display("FAIL watchdog actual=timeout expected=finish");
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

    initial begin
        t_reset_state();
        t_write(5, 1'b1, "R2 short low");
        t_write(60, 1'b0, "R2 long low");
        t_write(30, 1'b1, "R2 boundary 30");
        t_write(31, 1'b0, "R2 boundary 31");
        t_read(1'b0, 30, "R3 read zero");
        t_read(1'b1, 0, "R4 read one");
        t_reset_presence();
        t_recovery();
        t_write(5, 1'b1, "R2 after reset");
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end
endmodule